// File: doc/BRIEF.md
# Packet Header Deframer with Optional Timestamp

This block sits on a 64-bit AXI4-Stream link that carries framed packets. The first beat of each packet is a header word. The block takes that word apart into separate field outputs: packet kind, timestamp-present flag, end-of-burst flag, sequence number, byte length, and source and destination stream identifiers. When the header says a timestamp follows, the block captures the next beat as a 64-bit time value. The output stream carries only the payload beats. They pass through unchanged and keep their tlast.

Once the header section of a packet is complete, a one-cycle strobe marks the field outputs as valid. This happens after the header beat alone, or after the timestamp beat when one is present. The block also counts the beats of each packet, header and timestamp included, and compares the total against the byte length carried in the header. A length that matches neither a whole number of words nor a final word that is four bytes short raises an error pulse on the final beat.

Top module: `pkt_deframer`

## Requirements
- R1: Header fields are decoded from the header word as follows.
  - Bits [63:62] give the kind: 00 data, 01 flow control, 10 command, 11 response.
  - Bit 61 is timestamp-present and bit 60 is end-of-burst.
  - Bits [59:48] are the sequence number and bits [47:32] are the byte length.
  - Bits [31:16] are the source ID and bits [15:0] are the destination ID.
- R2: When bit 61 of the header is set and the header beat has no tlast, the next beat is captured on `hdr_time` and is not forwarded. Otherwise `hdr_time` reads zero.
- R3: Payload beats appear on the output in order, with data and tlast unchanged. No beat is lost or repeated under output backpressure.
- R4: A header beat carrying tlast ends the packet. Its fields are still reported, no timestamp is taken and no output beat is produced. The next beat is treated as a new header.
- R5: `hdr_valid` pulses for exactly one cycle per packet, in the cycle after the last header-section beat is accepted. That beat is the header, or the timestamp if one is present. All field outputs are valid during that pulse.
- R6: Let N be the total accepted beats of a packet (header, timestamp and payload). `len_err` is high in the cycle in which the final beat is accepted if and only if the byte length is neither 8N nor 8N-4. It is low in every other cycle.
- R7: `in_tready` is high while a header or timestamp beat is expected. During payload it equals `out_tready`.
- R8: Reset is synchronous and active low. It leaves `hdr_valid`, `len_err` and `out_tvalid` low and returns the block to expecting a header, even in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_tdata | input | 64 | Input stream data |
| in_tvalid | input | 1 | Input stream valid |
| in_tlast | input | 1 | Input stream end of packet |
| in_tready | output | 1 | Input stream ready |
| out_tdata | output | 64 | Payload data |
| out_tvalid | output | 1 | Payload valid |
| out_tlast | output | 1 | Payload end of packet |
| out_tready | input | 1 | Payload ready from downstream |
| hdr_valid | output | 1 | One-cycle strobe, header fields valid |
| hdr_kind | output | 2 | Packet kind |
| hdr_has_time | output | 1 | Timestamp-present flag |
| hdr_eob | output | 1 | End-of-burst flag |
| hdr_seq | output | 12 | Sequence number |
| hdr_len | output | 16 | Byte length from the header |
| hdr_src | output | 16 | Source stream ID |
| hdr_dst | output | 16 | Destination stream ID |
| hdr_time | output | 64 | Captured timestamp, zero when absent |
| len_err | output | 1 | Length mismatch pulse on the final beat |

## Verification
The hardest situations to reach from the ports are packets that end early. These are a header carrying tlast while its timestamp flag is set, and a timestamp beat that is itself the last beat. In both cases the beat count and the timestamp capture must behave differently from the usual path. The stimulus builds these packets on purpose, with exact, four-short and wrong lengths, and places them back to back so that header strobes fall in consecutive cycles. Random output backpressure runs during payload. A reset is also asserted right after a header beat, to show that the block again expects a header.

// File: rtl/pdf_pkg.sv
// Package: shared types for the packet deframer.
// The header structure mirrors the bit layout of the header word, so a
// plain cast of the 64-bit beat yields the decoded fields.
package pdf_pkg;

    localparam int WORD_W = 64;

    // Packet kind codes carried in the top two header bits.
    typedef enum logic [1:0] {
        KIND_DATA = 2'b00,
        KIND_FLOW = 2'b01,
        KIND_CMD  = 2'b10,
        KIND_RESP = 2'b11
    } pkt_kind_e;

    // Decoded header word, most significant field first.
    typedef struct packed {
        pkt_kind_e   kind;
        logic        has_time;
        logic        eob;
        logic [11:0] seq;
        logic [15:0] len;
        logic [15:0] src;
        logic [15:0] dst;
    } hdr_fields_t;

    // Which beat of a packet the deframer expects next.
    typedef enum logic [1:0] {
        PH_HDR  = 2'b00,
        PH_TIME = 2'b01,
        PH_BODY = 2'b10
    } phase_e;

endpackage

// File: rtl/pdf_phase_ctrl.sv
// Module: pdf_phase_ctrl
// Tracks which beat of a packet is expected: the header, the timestamp or the payload.
// It produces the capture enables and a registered strobe once the header section
// of a packet is complete.
// Assumes: `beat` is the accepted-beat handshake (valid and ready both high).
module pdf_phase_ctrl
    import pdf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   beat,
    input  logic   beat_last,
    input  logic   beat_time_flag,
    output phase_e phase,
    output logic   hdr_take,
    output logic   time_take,
    output logic   meta_done
);

    phase_e phase_q;
    phase_e phase_d;
    logic   meta_done_q;

    assign phase     = phase_q;
    assign hdr_take  = beat && (phase_q == PH_HDR);
    assign time_take = beat && (phase_q == PH_TIME);
    assign meta_done = meta_done_q;

    // Next-phase selection from the current phase and the accepted beat.
    always_comb begin
        phase_d = phase_q;
        if (beat) begin
            unique case (phase_q)
                PH_HDR:  phase_d = beat_last ? PH_HDR : (beat_time_flag ? PH_TIME : PH_BODY);
                PH_TIME: phase_d = beat_last ? PH_HDR : PH_BODY;
                PH_BODY: phase_d = beat_last ? PH_HDR : PH_BODY;
                default: phase_d = PH_HDR;
            endcase
        end
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_HDR;
        else        phase_q <= phase_d;
    end

    // Strobe one cycle after the last header-section beat is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) meta_done_q <= 1'b0;
        else        meta_done_q <= (hdr_take && (beat_last || !beat_time_flag)) || time_take;
    end

endmodule

// File: rtl/pdf_hdr_capture.sv
// Module: pdf_hdr_capture
// Holds the decoded header fields and the timestamp of the current packet.
// Assumes: `hdr_take` and `time_take` are never high together.
// A header clears the timestamp to zero, so a packet without a timestamp reads zero.
module pdf_hdr_capture
    import pdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_take,
    input  logic              time_take,
    input  logic [WORD_W-1:0] word,
    output hdr_fields_t       fields,
    output logic [WORD_W-1:0] stamp
);

    hdr_fields_t       fields_q;
    logic [WORD_W-1:0] stamp_q;

    assign fields = fields_q;
    assign stamp  = stamp_q;

    // Field register, loaded from the header beat.
    always_ff @(posedge clk) begin
        if (!rst_n)        fields_q <= '0;
        else if (hdr_take) fields_q <= hdr_fields_t'(word);
    end

    // Timestamp register, cleared by a header and loaded by the timestamp beat.
    always_ff @(posedge clk) begin
        if (!rst_n)         stamp_q <= '0;
        else if (hdr_take)  stamp_q <= '0;
        else if (time_take) stamp_q <= word;
    end

endmodule

// File: rtl/pdf_len_check.sv
// Module: pdf_len_check
// Counts the accepted beats of a packet and compares the total with the byte
// length from the header.
// Assumes: CNT_W >= 14, so that a saturated count can never look like a valid 16-bit length.
// The flag is combinational and is high only while the final beat is being accepted.
module pdf_len_check #(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat,
    input  logic        beat_last,
    input  logic        at_hdr,
    input  logic [15:0] live_len,
    input  logic [15:0] held_len,
    output logic        len_err
);

    localparam int BYTE_W = CNT_W + 3;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  total;
    logic [BYTE_W-1:0] bytes;
    logic [BYTE_W-1:0] want;
    logic              fits;

    // Beats so far including the current one, saturating at the top.
    always_comb begin
        if (at_hdr)              total = CNT_W'(1);
        else if (cnt_q == CNT_MAX) total = cnt_q;
        else                     total = cnt_q + CNT_W'(1);
    end

    // Byte comparison: accept a whole count of words or a last word four bytes short.
    always_comb begin
        bytes = {total, 3'b000};
        want  = BYTE_W'(at_hdr ? live_len : held_len);
        fits  = (bytes == want) || (bytes == want + BYTE_W'(4));
    end

    assign len_err = beat && beat_last && !fits;

    // Beat counter, cleared at the end of each packet.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (beat)     cnt_q <= beat_last ? '0 : total;
    end

endmodule

// File: rtl/pkt_deframer.sv
// Module: pkt_deframer (top)
// Strips the header word, and the timestamp word when the header asks for one,
// from 64-bit stream packets. The decoded fields are reported with a strobe, and
// the payload is forwarded unbuffered.
// Assumes: the upstream source follows AXI4-Stream rules (data held while not accepted).
module pkt_deframer
    import pdf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] in_tdata,
    input  logic        in_tvalid,
    input  logic        in_tlast,
    output logic        in_tready,
    output logic [63:0] out_tdata,
    output logic        out_tvalid,
    output logic        out_tlast,
    input  logic        out_tready,
    output logic        hdr_valid,
    output logic [1:0]  hdr_kind,
    output logic        hdr_has_time,
    output logic        hdr_eob,
    output logic [11:0] hdr_seq,
    output logic [15:0] hdr_len,
    output logic [15:0] hdr_src,
    output logic [15:0] hdr_dst,
    output logic [63:0] hdr_time,
    output logic        len_err
);

    phase_e      phase;
    logic        beat;
    logic        in_body;
    logic        hdr_take;
    logic        time_take;
    hdr_fields_t fields;
    hdr_fields_t live_hdr;

    assign live_hdr = hdr_fields_t'(in_tdata);
    assign in_body  = (phase == PH_BODY);

    // Ready is held high for header and timestamp beats, and follows downstream in the body.
    assign in_tready = in_body ? out_tready : 1'b1;
    assign beat      = in_tvalid && in_tready;

    // Payload passes straight through while in the body.
    assign out_tvalid = in_tvalid && in_body;
    assign out_tdata  = in_tdata;
    assign out_tlast  = in_tlast;

    pdf_phase_ctrl u_phase (
        .clk            (clk),
        .rst_n          (rst_n),
        .beat           (beat),
        .beat_last      (in_tlast),
        .beat_time_flag (live_hdr.has_time),
        .phase          (phase),
        .hdr_take       (hdr_take),
        .time_take      (time_take),
        .meta_done      (hdr_valid)
    );

    pdf_hdr_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_take  (hdr_take),
        .time_take (time_take),
        .word      (in_tdata),
        .fields    (fields),
        .stamp     (hdr_time)
    );

    pdf_len_check #(.CNT_W(CNT_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (beat),
        .beat_last (in_tlast),
        .at_hdr    (phase == PH_HDR),
        .live_len  (live_hdr.len),
        .held_len  (fields.len),
        .len_err   (len_err)
    );

    assign hdr_kind     = fields.kind;
    assign hdr_has_time = fields.has_time;
    assign hdr_eob      = fields.eob;
    assign hdr_seq      = fields.seq;
    assign hdr_len      = fields.len;
    assign hdr_src      = fields.src;
    assign hdr_dst      = fields.dst;

endmodule

// File: rtl/pdf_checker.sv
// Module: pdf_checker
// Port-level properties of the deframer, attached to the top through bind.
module pdf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_tvalid,
    input logic        in_tready,
    input logic        in_tlast,
    input logic        out_tvalid,
    input logic        out_tready,
    input logic        hdr_valid,
    input logic        hdr_has_time,
    input logic [63:0] hdr_time,
    input logic        len_err
);

    // R7: a beat that is offered but not forwarded is a header or timestamp beat, so it is always accepted.
    a_r7_meta_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tvalid && !out_tvalid) |-> in_tready);

    // R7: while payload is offered, the backpressure follows downstream.
    a_r7_body_ready: assert property (@(posedge clk) disable iff (!rst_n)
        out_tvalid |-> (in_tready == out_tready));

    // R5: the strobe follows an accepted beat.
    a_r5_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && $past(rst_n)) |-> $past(in_tvalid && in_tready));

    // R6: the length flag only appears on an accepted final beat.
    a_r6_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (in_tvalid && in_tready && in_tlast));

    // R2: without a timestamp flag the time output reads zero.
    a_r2_time_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_has_time) |-> (hdr_time == 64'd0));

endmodule

bind pkt_deframer pdf_checker u_pdf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_tvalid    (in_tvalid),
    .in_tready    (in_tready),
    .in_tlast     (in_tlast),
    .out_tvalid   (out_tvalid),
    .out_tready   (out_tready),
    .hdr_valid    (hdr_valid),
    .hdr_has_time (hdr_has_time),
    .hdr_time     (hdr_time),
    .len_err      (len_err)
);

// File: tb/tb_pkt_deframer.sv
// Bench for pkt_deframer: a scoreboard fed by the packet driver and drained by a monitor.
module tb_pkt_deframer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] in_tdata = '0;
    logic        in_tvalid = 1'b0;
    logic        in_tlast = 1'b0;
    logic        in_tready;
    logic [63:0] out_tdata;
    logic        out_tvalid;
    logic        out_tlast;
    logic        out_tready = 1'b1;
    logic        hdr_valid;
    logic [1:0]  hdr_kind;
    logic        hdr_has_time;
    logic        hdr_eob;
    logic [11:0] hdr_seq;
    logic [15:0] hdr_len;
    logic [15:0] hdr_src;
    logic [15:0] hdr_dst;
    logic [63:0] hdr_time;
    logic        len_err;

    int vectors = 0;
    int fails = 0;
    logic        tb_body = 1'b0;
    logic        tb_err = 1'b0;
    logic        bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic        done = 1'b0;

    logic [63:0] q_hdr[$];
    logic [63:0] q_time[$];
    logic [64:0] q_pay[$];

    always #4 clk = ~clk;

    pkt_deframer dut (.*);

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Random downstream backpressure, changed just after each rising edge.
    initial forever begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_tready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // Monitor: sample away from the rising edge and compare with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (in_tvalid) begin
                chk(in_tready == (tb_body ? out_tready : 1'b1), "R7 ready", {63'd0, in_tready}, {63'd0, tb_body ? out_tready : 1'b1});
                if (!tb_body) chk(!out_tvalid, "R2/R4 not forwarded", {63'd0, out_tvalid}, 64'd0);
            end
            chk(len_err == (in_tvalid && in_tready && in_tlast && tb_err), "R6 len_err", {63'd0, len_err},
                {63'd0, in_tvalid && in_tready && in_tlast && tb_err});
            if (out_tvalid && out_tready) begin
                if (q_pay.size() == 0) chk(1'b0, "R3/R4 unexpected beat", out_tdata, 64'd0);
                else begin
                    logic [64:0] e;
                    e = q_pay.pop_front();
                    chk({out_tlast, out_tdata} == e, "R3 payload", {out_tlast, out_tdata[62:0]}, {e[64], e[62:0]});
                end
            end
            if (hdr_valid) begin
                if (q_hdr.size() == 0) chk(1'b0, "R5 unexpected strobe", 64'd0, 64'd0);
                else begin
                    logic [63:0] h;
                    logic [63:0] t;
                    h = q_hdr.pop_front();
                    t = q_time.pop_front();
                    chk({hdr_kind, hdr_has_time, hdr_eob, hdr_seq, hdr_len, hdr_src, hdr_dst} == h, "R1 fields",
                        {hdr_kind, hdr_has_time, hdr_eob, hdr_seq, hdr_len, hdr_src, hdr_dst}, h);
                    chk(hdr_time == t, "R2 timestamp", hdr_time, t);
                end
            end
        end
    end

    // Drive one beat and wait until it has been accepted.
    task automatic push_beat(input logic [63:0] d, input logic last, input logic body, input logic err);
        logic ok;
        in_tdata = d;
        in_tlast = last;
        in_tvalid = 1'b1;
        tb_body = body;
        tb_err = err;
        do begin
            @(negedge clk);
            ok = in_tready;
            @(posedge clk);
            #1;
        end while (!ok);
        in_tvalid = 1'b0;
        in_tlast = 1'b0;
        tb_err = 1'b0;
        tb_body = 1'b0;
    endtask

    // Build one packet; len_mode 0 exact, 1 four bytes short, 2 wrong. Header-only when hdr_only.
    task automatic send_pkt(input logic [1:0] kind, input logic ht, input logic eob, input logic [11:0] seq,
                            input logic [15:0] src, input logic [15:0] dst, input logic [63:0] ts,
                            input int npl, input logic hdr_only, input int len_mode);
        int beats;
        logic [15:0] len;
        logic [63:0] hw;
        logic err;
        beats = hdr_only ? 1 : (1 + (ht ? 1 : 0) + npl);
        len = 16'(beats * 8 - (len_mode == 1 ? 4 : 0) + (len_mode == 2 ? 8 : 0));
        err = (len_mode == 2);
        hw = {kind, ht, eob, seq, len, src, dst};
        q_hdr.push_back(hw);
        q_time.push_back((ht && !hdr_only) ? ts : 64'd0);
        push_beat(hw, hdr_only || (!ht && npl == 0), 1'b0, err);
        if (!hdr_only) begin
            if (ht) push_beat(ts, npl == 0, 1'b0, err);
            for (int i = 0; i < npl; i++) begin
                logic [63:0] d;
                d = {seq, 20'h5A0F3, 32'(i * 32'h01010101 + 32'(dst))};
                q_pay.push_back({i == npl - 1, d});
                push_beat(d, i == npl - 1, 1'b1, err);
            end
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        @(negedge clk);
        chk(!hdr_valid && !len_err && !out_tvalid && in_tready, "R8 reset state",
            {60'd0, hdr_valid, len_err, out_tvalid, in_tready}, 64'd1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1/R3: each kind code, exact and four-short lengths
        send_pkt(2'b00, 1'b0, 1'b0, 12'h001, 16'h1111, 16'h2222, 64'd0, 3, 1'b0, 0);
        send_pkt(2'b01, 1'b0, 1'b1, 12'hFFF, 16'hFFFF, 16'h0001, 64'd0, 1, 1'b0, 1);
        send_pkt(2'b10, 1'b1, 1'b0, 12'h123, 16'hABCD, 16'h00FF, 64'hDEAD_BEEF_0123_4567, 4, 1'b0, 0);
        send_pkt(2'b11, 1'b1, 1'b1, 12'h800, 16'h8000, 16'h7FFF, 64'hFFFF_0000_FFFF_0001, 2, 1'b0, 1);
        // R4: header-only, with and without the time flag, back to back
        send_pkt(2'b10, 1'b0, 1'b0, 12'h010, 16'h0010, 16'h0020, 64'd0, 0, 1'b1, 0);
        send_pkt(2'b11, 1'b1, 1'b0, 12'h011, 16'h0030, 16'h0040, 64'h1234, 0, 1'b1, 1);
        send_pkt(2'b00, 1'b0, 1'b0, 12'h012, 16'h0050, 16'h0060, 64'd0, 0, 1'b1, 2);
        // R2: timestamp beat is the last beat
        send_pkt(2'b01, 1'b1, 1'b0, 12'h013, 16'h0070, 16'h0080, 64'hCAFE_F00D_0000_0042, 0, 1'b0, 0);
        // R6: wrong lengths on several shapes
        send_pkt(2'b00, 1'b0, 1'b0, 12'h020, 16'h0100, 16'h0200, 64'd0, 5, 1'b0, 2);
        send_pkt(2'b00, 1'b1, 1'b0, 12'h021, 16'h0300, 16'h0400, 64'h77, 0, 1'b0, 2);
        settle();
        // R3/R7: payload under random backpressure
        bp_en = 1'b1;
        for (int k = 0; k < 12; k++)
            send_pkt(2'(k), k[0], k[1], 12'(12'h100 + k), 16'(k), 16'(16'h0A00 + k), 64'(k * 64'h1111_0000_0001),
                     k + 1, 1'b0, k % 3);
        send_pkt(2'b00, 1'b0, 1'b0, 12'h200, 16'h0001, 16'h0002, 64'd0, 40, 1'b0, 1);
        bp_en = 1'b0;
        settle();
        // R8: reset just after a header beat, then a new header is expected
        send_pkt(2'b00, 1'b0, 1'b0, 12'h300, 16'h0003, 16'h0004, 64'd0, 0, 1'b1, 0);
        q_hdr.push_back({2'b00, 1'b0, 1'b0, 12'h301, 16'd24, 16'h0005, 16'h0006});
        q_time.push_back(64'd0);
        push_beat({2'b00, 1'b0, 1'b0, 12'h301, 16'd24, 16'h0005, 16'h0006}, 1'b0, 1'b0, 1'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        chk(!out_tvalid && !hdr_valid && in_tready, "R8 mid-packet reset", {61'd0, out_tvalid, hdr_valid, in_tready}, 64'd1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        send_pkt(2'b10, 1'b1, 1'b0, 12'h302, 16'h0007, 16'h0008, 64'h5555, 2, 1'b0, 0);
        settle();
        chk(q_hdr.size() == 0, "R5 all strobes seen", 64'(q_hdr.size()), 64'd0);
        chk(q_pay.size() == 0, "R3 all payload seen", 64'(q_pay.size()), 64'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule